// File: doc/BRIEF.md
# Multi-channel PWM duty update controller

This block holds a bank of PWM channels. Each channel has its own duty register, its own free-running 8-bit period counter and one output. Software reaches the bank through a plain register write port (address, data, strobe). It can change many duties with one trigger write, in either of two grouped ways.

In broadcast mode, one shared duty value is copied into every channel picked by a 32-bit channel mask. There is one mask address per group of 32 channels. In scatter mode, four independent duty values are staged first. A single write of four channel indices then moves all four into their targets in the same cycle. Fixed rules cover an index that names no channel and an index that appears more than once.

Every trigger write that is accepted makes the ready output drop for two cycles. While ready is low, further trigger writes are dropped. A new duty value waits in the channel and becomes active only when that channel's counter wraps to zero. This keeps a pulse that is already running from being cut short.

Top module: `pwm_duty_bank`

## Requirements
- R1: While reset is low, and after it is released, every duty register, the shared value and the four staged values are zero, ready is 1, and every PWM output is low.
- R2: A write to address 0 stores bits 7:0 as the shared value. A write to mask address 8+g copies the shared value into channel 32*g+i for every data bit i that is 1. Channels whose bit is 0 keep their duty.
- R3: Mask bits that map to channels at or above N_CH have no effect. A write to a mask address whose group does not exist changes no duty and leaves ready at 1.
- R4: Address 1 stores four staged duty fields, with field k in data bits 8k+7:8k. Address 2 holds four index fields in the same bit positions. A write to address 2 loads staged field k into the channel named by index field k, for all four fields in the same cycle.
- R5: An index field whose value is N_CH or larger is discarded, and no channel takes its staged value.
- R6: When several index fields name the same channel, that channel takes the staged value of the highest-numbered field.
- R7: An accepted trigger write (address 2, or an existing mask address) drives ready low for exactly the two cycles that follow the write edge. Ready is 1 again in the third cycle.
- R8: A trigger write made while ready is 0 is ignored and does not lengthen the busy time. Writes to addresses 0 and 1 are always stored.
- R9: Each channel counter counts 0 to 255 and wraps. The output is high while the counter is below the active duty, so it is high for exactly duty cycles out of every 256.
- R10: A newly written duty becomes active only at the edge where the counter wraps from 255 to 0. The rest of the current period keeps the old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| ready_o | output | 1 | High when a grouped update can be accepted |
| pwm_o | output | N_CH | PWM outputs, one per channel |

## Verification
Ready is due to fall in the cycle after the write edge and to return two cycles later. The bench drives each write at a falling edge and samples ready at the next three falling edges. Duty changes reach the outputs only after a counter wrap, up to 256 cycles later. The bench therefore waits 512 cycles before it counts high cycles over a full 256-cycle window per channel, and that count must equal the modelled duty. For the wrap rule, the bench keeps its own phase counter from reset release and checks the output at chosen counter phases before and after the first wrap that follows a mid-period write.

// File: rtl/pwm_bank_pkg.sv
// Package: shared widths and register addresses for the PWM duty bank.
// Assumes duty values and index fields are both 8 bits wide.
package pwm_bank_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int DUTY_W   = 8;
    localparam int FIELD_W  = 8;
    localparam int SLOTS    = 4;
    localparam int GRP_W    = 32;
    localparam int BUSY_CYC = 2;

    localparam logic [ADDR_W-1:0] A_COMMON = 4'd0;
    localparam logic [ADDR_W-1:0] A_MULTI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_SELECT = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASK0  = 4'd8;
endpackage

// File: rtl/pwm_update_ctrl.sv
// Module: pwm_update_ctrl
// Decodes register writes. It holds the shared value and the four staged
// values, runs the busy window, and produces one update strobe and value per
// channel. Assumes N_CH <= 32 * (number of mask addresses) and N_CH <= 64.
module pwm_update_ctrl
    import pwm_bank_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    output logic                   ready_o,
    output logic [N_CH-1:0]        upd_en_o,
    output logic [N_CH*DUTY_W-1:0] upd_val_o
);
    localparam int NGRP   = (N_CH + GRP_W - 1) / GRP_W;
    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    logic [DUTY_W-1:0]        common_q;
    logic [SLOTS*FIELD_W-1:0] multi_q;
    logic [BUSY_W-1:0]        busy_q;
    logic [NGRP-1:0]          grp_sel;
    logic                     take;
    logic                     sel_hit;
    logic                     trig;

    // Which existing mask group the current address names.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_sel[g] = (wr_addr_i == ADDR_W'(int'(A_MASK0) + g));
    end

    assign ready_o = (busy_q == '0);
    assign take    = wr_en_i && ready_o;
    assign sel_hit = take && (wr_addr_i == A_SELECT);
    assign trig    = sel_hit || (take && (|grp_sel));

    // Shared storage: written whenever addressed, independent of ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            common_q <= '0;
            multi_q  <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_COMMON) common_q <= wr_data_i[DUTY_W-1:0];
            if (wr_addr_i == A_MULTI)  multi_q  <= wr_data_i[SLOTS*FIELD_W-1:0];
        end
    end

    // Busy window: loaded by an accepted trigger, counts down to ready.
    always_ff @(posedge clk) begin
        if (!rst_n)           busy_q <= '0;
        else if (trig)        busy_q <= BUSY_W'(BUSY_CYC);
        else if (busy_q != 0) busy_q <= busy_q - 1'b1;
    end

    // Per-channel routing: mask broadcast first, then scatter slots in rising
    // order so that a higher slot overrides a lower one.
    for (genvar c = 0; c < N_CH; c++) begin : g_route
        localparam int G = c / GRP_W;
        localparam int B = c % GRP_W;
        logic              en_c;
        logic [DUTY_W-1:0] val_c;

        // Pick the strobe and value for this channel.
        always_comb begin
            en_c  = 1'b0;
            val_c = common_q;
            if (take && grp_sel[G] && wr_data_i[B]) begin
                en_c  = 1'b1;
                val_c = common_q;
            end
            for (int k = 0; k < SLOTS; k++) begin
                if (sel_hit && (wr_data_i[k*FIELD_W +: FIELD_W] == FIELD_W'(c))) begin
                    en_c  = 1'b1;
                    val_c = multi_q[k*FIELD_W +: DUTY_W];
                end
            end
        end

        assign upd_en_o[c]                   = en_c;
        assign upd_val_o[c*DUTY_W +: DUTY_W] = val_c;
    end
endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM channel: a pending duty register, an active duty register and a
// free-running counter. The pending value becomes active at the counter wrap.
// Assumes the counter width equals the duty width.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en_i,
    input  logic [DUTY_W-1:0] upd_val_i,
    output logic              pwm_o
);
    logic [DUTY_W-1:0] cnt_q;
    logic [DUTY_W-1:0] pend_q;
    logic [DUTY_W-1:0] act_q;

    // Period counter, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Pending duty takes grouped updates at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (upd_en_i) pend_q <= upd_val_i;
    end

    // Active duty follows the pending duty only at the wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_q <= '0;
        else if (&cnt_q)     act_q <= pend_q;
    end

    assign pwm_o = (cnt_q < act_q);
endmodule

// File: rtl/pwm_duty_bank.sv
// Module: pwm_duty_bank (top)
// Bank of N_CH PWM channels with broadcast and four-slot scatter duty updates,
// gated by a two-cycle ready window. Assumes 1 <= N_CH <= 64.
module pwm_duty_bank
    import pwm_bank_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_addr_i,
    input  logic [31:0]       wr_data_i,
    output logic              ready_o,
    output logic [N_CH-1:0]   pwm_o
);
    logic [N_CH-1:0]        upd_en;
    logic [N_CH*DUTY_W-1:0] upd_val;

    pwm_update_ctrl #(.N_CH(N_CH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ready_o   (ready_o),
        .upd_en_o  (upd_en),
        .upd_val_o (upd_val)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en_i  (upd_en[c]),
            .upd_val_i (upd_val[c*DUTY_W +: DUTY_W]),
            .pwm_o     (pwm_o[c])
        );
    end
endmodule

// File: rtl/pwm_duty_bank_chk.sv
// Module: pwm_duty_bank_chk
// Port-level checker for pwm_duty_bank, attached by bind. It keeps its own
// phase counter from reset release to check where outputs may rise.
module pwm_duty_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [3:0]      wr_addr_i,
    input logic            ready_o,
    input logic [N_CH-1:0] pwm_o
);
    localparam int NGRP = (N_CH + GRP_W - 1) / GRP_W;

    logic [DUTY_W-1:0] phase_q;
    logic              is_trig_addr;
    logic              accept;

    // Phase reference: mirrors a channel counter started at reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign is_trig_addr = (wr_addr_i == A_SELECT) ||
                          ((wr_addr_i >= A_MASK0) &&
                           (int'(wr_addr_i) < int'(A_MASK0) + NGRP));
    assign accept = wr_en_i && ready_o && is_trig_addr;

    // R1: reset leaves outputs low and ready high.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_o == '0) && ready_o);

    // R7: first busy cycle.
    p_busy_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready_o);

    // R7: second busy cycle.
    p_busy_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |=> !ready_o);

    // R7 / R8: busy never lasts more than two cycles.
    p_busy_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && $past(!ready_o)) |=> ready_o);

    // R3: a non-trigger write while ready keeps ready high.
    p_nontrigger_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ready_o && !is_trig_addr) |=> ready_o);

    // R10: an output can rise only at the start of a period.
    for (genvar c = 0; c < N_CH; c++) begin : g_rise
        p_rise_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_o[c] && !$past(pwm_o[c])) |-> (phase_q == '0));
    end
endmodule

bind pwm_duty_bank pwm_duty_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .ready_o   (ready_o),
    .pwm_o     (pwm_o)
);

// File: tb/pwm_duty_bank_tb.sv
// Directed bench for pwm_duty_bank with 40 channels (two mask groups).
module pwm_duty_bank_tb;
    import pwm_bank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic           ready;
    logic [NCH-1:0] pwm;

    int n_checks = 0;
    int n_errs   = 0;
    int tick     = 0;
    int exp_d [NCH];
    bit done     = 1'b0;

    pwm_duty_bank #(.N_CH(NCH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .ready_o   (ready),
        .pwm_o     (pwm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench phase: equals a channel counter value when read at a falling edge.
    always @(posedge clk) begin
        if (!rst_n) tick <= 0;
        else        tick <= tick + 1;
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        while ((tick % 256) != ph) @(negedge clk);
    endtask

    // Let updates pass a wrap, then count high cycles over one full period.
    task automatic measure(input string req);
        int hi [NCH];
        repeat (512) @(negedge clk);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        repeat (256) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (pwm[c]) hi[c]++;
        end
        for (int c = 0; c < NCH; c++)
            chk($sformatf("%s duty ch%0d", req, c), hi[c], exp_d[c]);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", int'(ready), 1);
        chk("R1 outputs low after reset", int'(pwm == '0), 1);
        measure("R1");
    endtask

    task automatic t_broadcast();
        wr(A_COMMON, 32'd77);
        wr(A_MASK0, 32'h0000_0005);
        chk("R7 ready low cycle 1", int'(ready), 0);
        @(negedge clk);
        chk("R7 ready low cycle 2", int'(ready), 0);
        @(negedge clk);
        chk("R7 ready back cycle 3", int'(ready), 1);
        exp_d[0] = 77;
        exp_d[2] = 77;
        measure("R2");
    endtask

    task automatic t_groups();
        wr(A_COMMON, 32'd120);
        wait_ready();
        wr(A_MASK0 + 4'd1, 32'hFFFF_FF08);   // bit3 -> ch35; bits 8+ absent
        wait_ready();
        exp_d[35] = 120;
        wr(A_MASK0 + 4'd2, 32'hFFFF_FFFF);   // group 2 does not exist
        chk("R3 absent group keeps ready", int'(ready), 1);
        measure("R3");
    endtask

    task automatic t_busy();
        wr(A_COMMON, 32'd50);
        wr(A_MASK0, 32'h0000_0010);          // ch4 accepted
        wr(A_COMMON, 32'd99);                // stored while busy
        wr(A_MASK0, 32'h0000_0020);          // ch5 while busy: ignored
        chk("R8 ignored trigger does not extend busy", int'(ready), 1);
        wait_ready();
        wr(A_MASK0, 32'h0000_0040);          // ch6 gets 99
        wait_ready();
        exp_d[4] = 50;
        exp_d[6] = 99;
        measure("R8");
    endtask

    task automatic t_scatter();
        wr(A_MULTI, {8'd40, 8'd30, 8'd20, 8'd10});
        wr(A_SELECT, {8'd13, 8'd12, 8'd11, 8'd10});
        chk("R7 ready low after scatter", int'(ready), 0);
        wait_ready();
        exp_d[10] = 10; exp_d[11] = 20; exp_d[12] = 30; exp_d[13] = 40;
        measure("R4");
    endtask

    task automatic t_range();
        wr(A_MULTI, {8'd88, 8'd77, 8'd66, 8'd55});
        wr(A_SELECT, {8'd17, 8'd16, 8'd15, 8'd40});  // slot 0 index = N_CH
        wait_ready();
        exp_d[15] = 66; exp_d[16] = 77; exp_d[17] = 88;
        measure("R5");
    endtask

    task automatic t_dup();
        wr(A_MULTI, {8'd150, 8'd140, 8'd130, 8'd120});
        wr(A_SELECT, {8'd20, 8'd21, 8'd20, 8'd20});
        wait_ready();
        exp_d[20] = 150; exp_d[21] = 140;
        measure("R6");
    endtask

    task automatic t_shape();
        wr(A_COMMON, 32'd255);
        wr(A_MASK0, 32'h0040_0000);          // ch22 = 255
        wait_ready();
        exp_d[22] = 255;
        measure("R9");
        wait_phase(76);
        chk("R9 ch0 high at phase 76", int'(pwm[0]), 1);
        @(negedge clk);
        chk("R9 ch0 low at phase 77", int'(pwm[0]), 0);
        wait_phase(254);
        chk("R9 ch22 high at phase 254", int'(pwm[22]), 1);
        @(negedge clk);
        chk("R9 ch22 low at phase 255", int'(pwm[22]), 0);
    endtask

    task automatic t_wrap();
        wr(A_MULTI, {8'd0, 8'd0, 8'd0, 8'd200});
        wr(A_SELECT, {8'd63, 8'd63, 8'd63, 8'd3});
        wait_ready();
        exp_d[3] = 200;
        measure("R10 setup");
        wait_phase(40);
        wr(A_MULTI, {8'd0, 8'd0, 8'd0, 8'd10});
        wr(A_SELECT, {8'd63, 8'd63, 8'd63, 8'd3});
        wait_phase(150);
        chk("R10 old duty holds to period end", int'(pwm[3]), 1);
        @(negedge clk);
        wait_phase(5);
        chk("R10 new duty high at phase 5", int'(pwm[3]), 1);
        wait_phase(150);
        chk("R10 new duty low at phase 150", int'(pwm[3]), 0);
        exp_d[3] = 10;
        measure("R10");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) exp_d[c] = 0;
        repeat (4) @(negedge clk);
        chk("R1 outputs low during reset", int'(pwm == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broadcast();
        t_groups();
        t_busy();
        t_scatter();
        t_range();
        t_dup();
        t_shape();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule